// File: doc/BRIEF.md
# E1 Channel-Associated Signaling Extractor

This block sits behind an E1 frame and multiframe synchronizer. It takes the received byte stream together with the time-slot index, the frame number within the multiframe and a multiframe-lock flag. It picks out the signaling slot (slot 16) of every frame and splits that byte into two 4-bit ABCD codes. It then files each code into a per-channel register for the 30 voice channels. Frame n (1 to 15) serves channel n with its high nibble and channel n+15 with its low nibble. A full refresh of all channels therefore takes fifteen frames.

A received code is committed only when it matches the code that arrived for the same channel one multiframe earlier. This gives a plain repeat check against single-frame errors. A commit that alters a channel's stored code emits a one-cycle change strobe carrying the channel number and the new code. An all-zero code is not valid signaling. It raises an error pulse and is never stored. While multiframe lock is absent, or while the clear-channel mode is set, the block accepts nothing and every register keeps its value. A combinational read port returns the stored code of any channel.

Top module: `e1_cas_extract`

## Requirements
- R1: Only a byte presented with `byte_valid` high and `slot_idx` equal to 16 is taken; bytes in any other slot, or with `byte_valid` low, cause no strobe, no error and no register change.
- R2: A byte taken in frame n (1..15) at clock edge k delivers its high nibble (bits 7:4) as channel n, with its result at the outputs after edge k+1. It delivers its low nibble (bits 3:0) as channel n+15, with its result at the outputs after edge k+2.
- R3: A byte taken in frame 0 updates no channel and produces neither a strobe nor an error.
- R4: A delivered nibble of 0000 pulses `sig_err` for one cycle with `err_chan` set to its channel number, and is neither stored nor used as the repeat reference.
- R5: A non-zero nibble is committed to a channel's stored code only when it equals the previous non-zero nibble accepted for that channel; the reference is then updated to the new nibble.
- R6: A commit that changes the stored code pulses `chg_stb` for one cycle with `chg_chan` (channel number 1..30) and `chg_abcd` (new code). A commit of the code already stored gives no strobe.
- R7: While `mf_locked` is low at the capture edge, the byte is ignored and all stored and reference codes are held.
- R8: While `clear_chan` is high at the capture edge, the byte is ignored and all stored and reference codes are held.
- R9: After reset every channel reads the code 1101 and no strobe or error is active.
- R10: `rd_abcd` shows, in the same cycle, the stored code of channel `rd_chan` (1..30), and 0000 for any other index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Received byte qualifier |
| byte_in | input | 8 | Received slot byte |
| slot_idx | input | 5 | Time-slot index of the byte (0..31) |
| frame_idx | input | 4 | Frame number within the multiframe (0..15) |
| mf_locked | input | 1 | Multiframe alignment present |
| clear_chan | input | 1 | Clear-channel mode: slot 16 treated as data |
| rd_chan | input | 5 | Channel number to read (1..30) |
| rd_abcd | output | 4 | Stored code of `rd_chan` |
| chg_stb | output | 1 | One-cycle change strobe |
| chg_chan | output | 5 | Channel number of the change |
| chg_abcd | output | 4 | New code of the changed channel |
| sig_err | output | 1 | One-cycle invalid (0000) code pulse |
| err_chan | output | 5 | Channel number of the invalid code |

## Verification
A wrong routing of nibbles shows as a strobe naming the wrong channel one or two cycles after the slot-16 byte. It also leaves a wrong code on the read port once the second matching multiframe has been seen. A corrupted repeat reference shows only one multiframe later, as a missing or spurious commit. For that reason the bench always sends each pattern over two multiframes and reads back all 30 channels after each phase. A leak through the frozen modes shows as a strobe within two cycles of the ignored byte, or as a changed code at the next read sweep.

// File: rtl/e1_cas_pkg.sv
package e1_cas_pkg;
  localparam int SIG_CHANNELS = 30;
  localparam int CHAN_W       = 5;
  localparam int FRAME_W      = 4;
  localparam int SLOT_W       = 5;
  localparam int NIB_W        = 4;
  localparam int SIG_SLOT     = 16;
  localparam logic [NIB_W-1:0] IDLE_CODE = 4'b1101;

  // channel served by the high nibble of the signaling slot in frame f
  function automatic logic [CHAN_W-1:0] upper_chan(input logic [FRAME_W-1:0] f);
    return CHAN_W'(f);
  endfunction

  // channel served by the low nibble: shifted by half the channel count
  function automatic logic [CHAN_W-1:0] lower_chan(input logic [FRAME_W-1:0] f);
    return CHAN_W'(f) + CHAN_W'(SIG_CHANNELS / 2);
  endfunction

  // frame 0 carries the multiframe marker, not channel codes
  function automatic logic frame_has_codes(input logic [FRAME_W-1:0] f);
    return f != '0;
  endfunction

  function automatic logic code_invalid(input logic [NIB_W-1:0] n);
    return n == '0;
  endfunction

  function automatic logic chan_in_range(input logic [CHAN_W-1:0] c);
    return (c >= CHAN_W'(1)) && (c <= CHAN_W'(SIG_CHANNELS));
  endfunction
endpackage

// File: rtl/cas_slot_capture.sv
module cas_slot_capture
  import e1_cas_pkg::*;
#(
  parameter int CW = CHAN_W,
  parameter int FW = FRAME_W,
  parameter int SW = SLOT_W,
  parameter int NW = NIB_W,
  parameter int SLOT_SEL = SIG_SLOT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [2*NW-1:0] byte_in,
  input  logic [SW-1:0] slot_idx,
  input  logic [FW-1:0] frame_idx,
  input  logic          mf_locked,
  input  logic          clear_chan,
  output logic          take,
  output logic          ev_vld,
  output logic [CW-1:0] ev_chan,
  output logic [NW-1:0] ev_nib
);
  logic          hold_vld;
  logic [CW-1:0] hold_chan;
  logic [NW-1:0] hold_nib;

  assign take = byte_valid && (slot_idx == SW'(SLOT_SEL)) && mf_locked
                && !clear_chan && frame_has_codes(frame_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_vld    <= 1'b0;
      ev_chan   <= '0;
      ev_nib    <= '0;
      hold_vld  <= 1'b0;
      hold_chan <= '0;
      hold_nib  <= '0;
    end else if (take) begin
      ev_vld    <= 1'b1;
      ev_chan   <= upper_chan(frame_idx);
      ev_nib    <= byte_in[2*NW-1:NW];
      hold_vld  <= 1'b1;
      hold_chan <= lower_chan(frame_idx);
      hold_nib  <= byte_in[NW-1:0];
    end else if (hold_vld) begin
      ev_vld    <= 1'b1;
      ev_chan   <= hold_chan;
      ev_nib    <= hold_nib;
      hold_vld  <= 1'b0;
    end else begin
      ev_vld    <= 1'b0;
    end
  end
endmodule

// File: rtl/cas_chan_bank.sv
module cas_chan_bank
  import e1_cas_pkg::*;
#(
  parameter int NCH = SIG_CHANNELS,
  parameter int CW  = CHAN_W,
  parameter int NW  = NIB_W,
  parameter logic [NIB_W-1:0] RST_CODE = IDLE_CODE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_vld,
  input  logic [CW-1:0] ev_chan,
  input  logic [NW-1:0] ev_nib,
  input  logic [CW-1:0] rd_chan,
  output logic [NW-1:0] rd_abcd,
  output logic          commit_chg,
  output logic          chg_stb,
  output logic [CW-1:0] chg_chan,
  output logic [NW-1:0] chg_abcd,
  output logic          sig_err,
  output logic [CW-1:0] err_chan
);
  logic [NW-1:0] cand_q   [NCH];
  logic [NW-1:0] stored_q [NCH];
  logic [CW-1:0] ev_idx;
  logic [CW-1:0] rd_idx;
  logic          ev_ok;
  logic          ev_zero;
  logic          ev_repeat;

  assign ev_idx    = ev_chan - CW'(1);
  assign rd_idx    = rd_chan - CW'(1);
  assign ev_ok     = ev_vld && chan_in_range(ev_chan);
  assign ev_zero   = code_invalid(ev_nib);
  assign ev_repeat = ev_ok && (cand_q[ev_idx] == ev_nib);
  assign commit_chg = ev_ok && !ev_zero && ev_repeat && (stored_q[ev_idx] != ev_nib);
  assign rd_abcd   = chan_in_range(rd_chan) ? stored_q[rd_idx] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic hit;
    assign hit = ev_ok && !ev_zero && (ev_chan == CW'(i + 1));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cand_q[i]   <= '0;
        stored_q[i] <= RST_CODE;
      end else if (hit) begin
        cand_q[i] <= ev_nib;
        if (cand_q[i] == ev_nib) stored_q[i] <= ev_nib;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_stb  <= 1'b0;
      chg_chan <= '0;
      chg_abcd <= '0;
      sig_err  <= 1'b0;
      err_chan <= '0;
    end else begin
      chg_stb  <= commit_chg;
      sig_err  <= ev_ok && ev_zero;
      if (commit_chg) begin
        chg_chan <= ev_chan;
        chg_abcd <= ev_nib;
      end
      if (ev_ok && ev_zero) err_chan <= ev_chan;
    end
  end
endmodule

// File: rtl/e1_cas_extract.sv
module e1_cas_extract
  import e1_cas_pkg::*;
#(
  parameter int NCH = SIG_CHANNELS,
  parameter int CW  = CHAN_W,
  parameter int FW  = FRAME_W,
  parameter int SW  = SLOT_W,
  parameter int NW  = NIB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [7:0]    byte_in,
  input  logic [SW-1:0] slot_idx,
  input  logic [FW-1:0] frame_idx,
  input  logic          mf_locked,
  input  logic          clear_chan,
  input  logic [CW-1:0] rd_chan,
  output logic [NW-1:0] rd_abcd,
  output logic          chg_stb,
  output logic [CW-1:0] chg_chan,
  output logic [NW-1:0] chg_abcd,
  output logic          sig_err,
  output logic [CW-1:0] err_chan
);
  logic          take;
  logic          ev_vld;
  logic [CW-1:0] ev_chan;
  logic [NW-1:0] ev_nib;
  logic          commit_chg;

  cas_slot_capture #(.CW(CW), .FW(FW), .SW(SW), .NW(NW)) u_cap (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
    .slot_idx(slot_idx), .frame_idx(frame_idx), .mf_locked(mf_locked),
    .clear_chan(clear_chan), .take(take), .ev_vld(ev_vld),
    .ev_chan(ev_chan), .ev_nib(ev_nib)
  );

  cas_chan_bank #(.NCH(NCH), .CW(CW), .NW(NW)) u_bank (
    .clk(clk), .rst_n(rst_n), .ev_vld(ev_vld), .ev_chan(ev_chan),
    .ev_nib(ev_nib), .rd_chan(rd_chan), .rd_abcd(rd_abcd),
    .commit_chg(commit_chg), .chg_stb(chg_stb), .chg_chan(chg_chan),
    .chg_abcd(chg_abcd), .sig_err(sig_err), .err_chan(err_chan)
  );
endmodule

// File: rtl/e1_cas_extract_chk.sv
module e1_cas_extract_chk #(
  parameter int NCH = 30,
  parameter int CW  = 5,
  parameter int NW  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mf_locked,
  input logic          clear_chan,
  input logic          take,
  input logic          chg_stb,
  input logic [CW-1:0] chg_chan,
  input logic [NW-1:0] chg_abcd,
  input logic          sig_err,
  input logic [CW-1:0] err_chan
);
  AST_STB_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_stb |-> (chg_chan >= CW'(1) && chg_chan <= CW'(NCH)));  // R2
  AST_STB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    chg_stb |-> chg_abcd != '0);  // R4
  AST_ERR_NOT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sig_err |-> (!chg_stb && err_chan >= CW'(1) && err_chan <= CW'(NCH)));  // R6
  AST_FROZEN_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mf_locked, 2) && !$past(mf_locked, 3)) |-> (!chg_stb && !sig_err));  // R7
  AST_FROZEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clear_chan, 2) && $past(clear_chan, 3)) |-> (!chg_stb && !sig_err));  // R8
  AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (mf_locked && !clear_chan));  // R7
endmodule

bind e1_cas_extract e1_cas_extract_chk #(.NCH(NCH), .CW(CW), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mf_locked(mf_locked), .clear_chan(clear_chan),
  .take(take), .chg_stb(chg_stb), .chg_chan(chg_chan), .chg_abcd(chg_abcd),
  .sig_err(sig_err), .err_chan(err_chan)
);

// File: tb/e1_cas_extract_test.sv
module e1_cas_extract_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = '0;
  logic [4:0] slot_idx = '0;
  logic [3:0] frame_idx = '0;
  logic       mf_locked = 1'b0;
  logic       clear_chan = 1'b0;
  logic [4:0] rd_chan = '0;
  logic [3:0] rd_abcd;
  logic       chg_stb;
  logic [4:0] chg_chan;
  logic [3:0] chg_abcd;
  logic       sig_err;
  logic [4:0] err_chan;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [3:0] m_cand   [1:NCH];
  logic [3:0] m_stored [1:NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_cas_extract uut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
    .slot_idx(slot_idx), .frame_idx(frame_idx), .mf_locked(mf_locked),
    .clear_chan(clear_chan), .rd_chan(rd_chan), .rd_abcd(rd_abcd),
    .chg_stb(chg_stb), .chg_chan(chg_chan), .chg_abcd(chg_abcd),
    .sig_err(sig_err), .err_chan(err_chan)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: returns expected strobe / error for one nibble
  task automatic model(input int ch, input logic [3:0] nib, input bit gate,
                       output bit stb, output bit err);
    stb = 1'b0; err = 1'b0;
    if (gate) begin
      if (nib == 4'd0) err = 1'b1;
      else begin
        stb = (m_cand[ch] == nib) && (m_stored[ch] != nib);
        if (m_cand[ch] == nib) m_stored[ch] = nib;
        m_cand[ch] = nib;
      end
    end
  endtask

  task automatic check_cycle(input string req, input int ch, input logic [3:0] nib,
                             input bit es, input bit ee);
    check(chg_stb == es, {req, " strobe"}, chg_stb, es);
    if (es) begin
      check(chg_chan == 5'(ch), {req, " chan"}, chg_chan, ch);
      check(chg_abcd == nib, {req, " code"}, chg_abcd, nib);
    end
    check(sig_err == ee, {req, "/R4 err"}, sig_err, ee);
    if (ee) check(err_chan == 5'(ch), "R4 err_chan", err_chan, ch);
  endtask

  // called and returns at a falling edge
  task automatic put(input logic [4:0] slot, input logic [3:0] fr, input logic [7:0] b,
                     input bit vld, input string req);
    bit gate, su, eu, sl, el;
    int cu, cl;
    gate = vld && (slot == 5'd16) && mf_locked && !clear_chan && (fr != 4'd0);
    cu = int'(fr);
    cl = int'(fr) + NCH / 2;
    if (gate) begin
      model(cu, b[7:4], 1'b1, su, eu);
      model(cl, b[3:0], 1'b1, sl, el);
    end else begin
      su = 0; eu = 0; sl = 0; el = 0;
    end
    byte_valid = vld; slot_idx = slot; frame_idx = fr; byte_in = b;
    @(negedge clk);
    byte_valid = 1'b0;
    @(negedge clk);
    check_cycle({req, "/R2 high"}, cu, b[7:4], su, eu);
    @(negedge clk);
    check_cycle({req, "/R2 low"}, cl, b[3:0], sl, el);
  endtask

  function automatic logic [3:0] pat(input int ch, input int k, input bit zeros);
    if (zeros && (ch % 7 == k % 7)) return 4'd0;
    return 4'(((ch * (k + 3) + k) % 15) + 1);
  endfunction

  task automatic send_mf(input int k, input bit zeros, input string req);
    put(5'd16, 4'd0, 8'h0B, 1'b1, "R3");
    for (int f = 1; f < 16; f++)
      put(5'd16, 4'(f), {pat(f, k, zeros), pat(f + NCH / 2, k, zeros)}, 1'b1, req);
  endtask

  task automatic sweep(input string req);
    for (int c = 0; c < 32; c++) begin
      rd_chan = 5'(c);
      #1;
      if (c >= 1 && c <= NCH) check(rd_abcd == m_stored[c], req, rd_abcd, m_stored[c]);
      else check(rd_abcd == 4'd0, "R10 out of range", rd_abcd, 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 1; c <= NCH; c++) begin m_cand[c] = 4'd0; m_stored[c] = 4'b1101; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(chg_stb == 1'b0, "R9 strobe idle", chg_stb, 0);
    check(sig_err == 1'b0, "R9 error idle", sig_err, 0);
    sweep("R9 reset code");
    mf_locked = 1'b1;
    // R5/R6: a pattern counts only after it repeats over two multiframes
    send_mf(0, 0, "R5");
    sweep("R5 single pass keeps old code");
    send_mf(0, 0, "R6");
    sweep("R6 committed");
    // R5: alternating patterns never commit
    send_mf(1, 0, "R5");
    send_mf(2, 0, "R5");
    send_mf(1, 0, "R5");
    sweep("R5 alternating");
    send_mf(1, 0, "R6");
    sweep("R6 second commit");
    send_mf(1, 0, "R6 same code");
    // R4: zero codes are flagged and not kept
    send_mf(3, 1, "R4");
    send_mf(3, 1, "R4");
    sweep("R4 zeros not stored");
    // R1: wrong slot and invalid bytes ignored
    for (int s = 0; s < 32; s++)
      if (s != 16) put(5'(s), 4'(s % 16), 8'h5A, 1'b1, "R1 slot");
    put(5'd16, 4'd4, 8'h77, 1'b0, "R1 invalid");
    sweep("R1 untouched");
    // R7: frozen without multiframe lock
    mf_locked = 1'b0;
    send_mf(4, 0, "R7");
    send_mf(4, 1, "R7");
    send_mf(4, 0, "R7");
    sweep("R7 held");
    // R8: clear-channel mode
    mf_locked = 1'b1;
    clear_chan = 1'b1;
    send_mf(5, 0, "R8");
    send_mf(5, 0, "R8");
    sweep("R8 held");
    clear_chan = 1'b0;
    send_mf(5, 0, "R5 after freeze");
    send_mf(5, 0, "R6 after freeze");
    sweep("R6 final");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule